// File: doc/BRIEF.md
# Translation and Cache Access Sequencer

This block carries one load or store from a virtual address to its data. A virtual page number is first looked up in a four-entry micro-TLB. On a miss it is looked up in a sixteen-entry main TLB. If both miss, the block asks an external walker for the translation. A translation that succeeds is written into both TLBs. A fault ends the access with an abort.

The translation carries two attribute bits: a cacheable flag and a write-back/write-through flag. A non-cacheable access goes straight to a physical bus cycle. A cacheable access looks up L1, then L2 on an L1 miss, then the bus on an L2 miss. Read hits return the data of the level that hit. A write hit in write-back mode updates the line and marks it dirty. A write hit in write-through mode updates the line and then also writes to the bus.

The walker, the two cache levels and the bus sit outside the block. Each one has a request that is held until its acknowledge arrives. Only one access is in flight at a time.

Top module: `xlate_access_seq`

## Requirements
- R1: The micro-TLB is looked up first, in one cycle after acceptance. On a hit the main TLB and the walker are not used.
- R2: On a micro-TLB miss the main TLB is looked up in the next cycle. A hit copies that entry into the micro-TLB, so the next access to the same page hits the micro-TLB.
- R3: When both TLBs miss, `walkReq` is raised with `walkVpn` equal to the virtual address bits above the 12-bit page offset. A successful result is written into both TLBs before the access continues.
- R4: A walk fault ends the access with a one-cycle `respAbort` and no cache or bus request. The fault is not stored, so the next access to that page walks again.
- R5: Both TLBs replace entries in round-robin order: the micro-TLB over 4 entries and the main TLB over 16 entries. A page evicted from both is walked again.
- R6: A non-cacheable translation (`walkCacheable`=0) goes straight to a single bus cycle and makes no L1 or L2 request.
- R7: A cacheable access requests L1, then L2 on an L1 miss, then the bus on an L2 miss. `accPaddr` is the 20-bit physical page number followed by the 12-bit page offset.
- R8: A read completes with `respDone` for one cycle. At the same time `respRdata` holds the data of the level that answered.
- R9: In write-back mode (`walkWriteBack`=1), every cache lookup of a write drives `cacheDirty`=1. A write hit then completes with no bus cycle.
- R10: In write-through mode, a write hit drives `cacheDirty`=0 and is followed by a bus write of the same address and data.
- R11: A write that misses both L1 and L2 is issued as a bus write and is not allocated.
- R12: `reqReady` is high only when idle. Each accepted request ends with exactly one one-cycle `respDone` or `respAbort`. At most one downstream request is active, and it is held until its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request |
| reqReady | output | 1 | Block idle, request taken this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqVaddr | input | 32 | Virtual address |
| reqWdata | input | 32 | Store data |
| respDone | output | 1 | Access completed |
| respAbort | output | 1 | Access ended by a translation fault |
| respRdata | output | 32 | Load data, valid with respDone |
| walkReq | output | 1 | Table walk request |
| walkVpn | output | 20 | Page number to translate |
| walkAck | input | 1 | Walk result valid |
| walkFault | input | 1 | Walk found no valid mapping |
| walkPpn | input | 20 | Physical page number from the walk |
| walkCacheable | input | 1 | Page is cacheable |
| walkWriteBack | input | 1 | Page uses write-back (1) or write-through (0) |
| accPaddr | output | 32 | Physical address for cache and bus |
| accWrite | output | 1 | Current access is a write |
| accWdata | output | 32 | Write data for cache and bus |
| cacheDirty | output | 1 | Mark the line dirty on a write hit |
| l1Req | output | 1 | L1 lookup request |
| l1Ack | input | 1 | L1 answer valid |
| l1Hit | input | 1 | L1 holds the line |
| l1Rdata | input | 32 | L1 read data |
| l2Req | output | 1 | L2 lookup request |
| l2Ack | input | 1 | L2 answer valid |
| l2Hit | input | 1 | L2 holds the line |
| l2Rdata | input | 32 | L2 read data |
| busReq | output | 1 | Physical bus cycle request |
| busAck | input | 1 | Bus cycle complete |
| busRdata | input | 32 | Bus read data |

## Verification
The in-RTL assertions check on every cycle a set of local rules:
- a page that was just refilled must hit the micro-TLB;
- no TLB holds two entries for one page;
- a walk fault leads straight to an abort with no memory request;
- caches are never asked for non-cacheable pages;
- L2 is requested only after an L1 miss;
- the write policy picks between finishing and a bus write after a hit;
- each response is a one-cycle pulse.

Other behaviours span several accesses and only the bench's scenarios can show them: round-robin eviction across both TLBs, promotion from the main TLB into the micro-TLB, and re-walking a faulting page. The bench's reference model predicts the port activity of every cycle, together with the address, the dirty mark and the returned data.

// File: rtl/xlseq_pkg.sv
package xlseq_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 32;
  localparam int PAGE_W = 12;
  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int PPN_W  = PA_W - PAGE_W;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic             cacheable;
    logic             writeBack;
  } xlAttr_t;

  typedef enum logic [1:0] {SRC_UTLB, SRC_MTLB, SRC_WALK} xlSrc_e;
  typedef enum logic [1:0] {RD_L1, RD_L2, RD_BUS} rdSrc_e;

  typedef struct packed {
    logic   capture;
    logic   latchXl;
    xlSrc_e xlSrc;
    logic   fillU;
    logic   fillM;
    logic   latchRd;
    rdSrc_e rdSrc;
  } strobe_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LOOKU, ST_LOOKM, ST_WALK, ST_ATTR,
    ST_L1, ST_L2, ST_BUS, ST_DONE, ST_ABORT
  } state_e;
endpackage

// File: rtl/xlseq_tlb.sv
module xlseq_tlb import xlseq_pkg::*; #(
  parameter int ENTRIES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VPN_W-1:0] lookupVpn,
  output logic             hit,
  output xlAttr_t          hitAttr,
  input  logic             fillEn,
  input  logic [VPN_W-1:0] fillVpn,
  input  xlAttr_t          fillAttr
);
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int ATTR_W = $bits(xlAttr_t);

  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] matchVec;
  logic [VPN_W-1:0]   tagQ  [ENTRIES];
  xlAttr_t            attrQ [ENTRIES];
  logic [PTR_W-1:0]   ptrQ;
  logic [ATTR_W-1:0]  attrAcc;

  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign matchVec[g] = validQ[g] && (tagQ[g] == lookupVpn);
  end

  always_comb begin
    attrAcc = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) attrAcc = attrAcc | attrQ[i];
    end
  end

  assign hit     = |matchVec;
  assign hitAttr = xlAttr_t'(attrAcc);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      ptrQ   <= '0;
    end else if (fillEn) begin
      validQ[ptrQ] <= 1'b1;
      ptrQ         <= (ptrQ == PTR_W'(ENTRIES - 1)) ? '0 : ptrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fillEn) begin
      tagQ[ptrQ]  <= fillVpn;
      attrQ[ptrQ] <= fillAttr;
    end
  end

  AST_TLB_UNIQUE: assert property (@(posedge clk) disable iff (!rstN) $onehot0(matchVec)); // R5
endmodule

// File: rtl/xlseq_dp.sv
module xlseq_dp import xlseq_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int UTLB_N = 4,
  parameter int MTLB_N = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              reqWrite,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [PPN_W-1:0]  walkPpn,
  input  logic              walkCacheable,
  input  logic              walkWriteBack,
  input  logic [DATA_W-1:0] l1Rdata,
  input  logic [DATA_W-1:0] l2Rdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              uHit,
  output logic              mHit,
  output logic              xlCacheable,
  output logic              xlWriteBack,
  output logic [VPN_W-1:0]  walkVpn,
  output logic [PA_W-1:0]   accPaddr,
  output logic              accWrite,
  output logic [DATA_W-1:0] accWdata,
  output logic [DATA_W-1:0] respRdata
);
  logic [VA_W-1:0]   vaddrQ;
  logic              writeQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  xlAttr_t           xlQ;
  xlAttr_t           uAttr;
  xlAttr_t           mAttr;
  xlAttr_t           walkAttr;
  xlAttr_t           uFillAttr;
  logic [VPN_W-1:0]  curVpn;

  assign curVpn    = vaddrQ[VA_W-1:PAGE_W];
  assign walkAttr  = '{ppn: walkPpn, cacheable: walkCacheable, writeBack: walkWriteBack};
  assign uFillAttr = (stb.xlSrc == SRC_WALK) ? walkAttr : mAttr;

  xlseq_tlb #(.ENTRIES(UTLB_N)) u_utlb (
    .clk(clk), .rstN(rstN), .lookupVpn(curVpn), .hit(uHit), .hitAttr(uAttr),
    .fillEn(stb.fillU), .fillVpn(curVpn), .fillAttr(uFillAttr)
  );

  xlseq_tlb #(.ENTRIES(MTLB_N)) u_mtlb (
    .clk(clk), .rstN(rstN), .lookupVpn(curVpn), .hit(mHit), .hitAttr(mAttr),
    .fillEn(stb.fillM), .fillVpn(curVpn), .fillAttr(walkAttr)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
      rdataQ <= '0;
      xlQ    <= '0;
    end else begin
      if (stb.capture) begin
        vaddrQ <= reqVaddr;
        writeQ <= reqWrite;
        wdataQ <= reqWdata;
      end
      if (stb.latchXl) begin
        case (stb.xlSrc)
          SRC_UTLB: xlQ <= uAttr;
          SRC_MTLB: xlQ <= mAttr;
          default:  xlQ <= walkAttr;
        endcase
      end
      if (stb.latchRd) begin
        case (stb.rdSrc)
          RD_L1:   rdataQ <= l1Rdata;
          RD_L2:   rdataQ <= l2Rdata;
          default: rdataQ <= busRdata;
        endcase
      end
    end
  end

  assign xlCacheable = xlQ.cacheable;
  assign xlWriteBack = xlQ.writeBack;
  assign walkVpn     = curVpn;
  assign accPaddr    = {xlQ.ppn, vaddrQ[PAGE_W-1:0]};
  assign accWrite    = writeQ;
  assign accWdata    = wdataQ;
  assign respRdata   = rdataQ;

  AST_REFILL_HITS: assert property (@(posedge clk) disable iff (!rstN) stb.fillU |=> uHit); // R3
endmodule

// File: rtl/xlseq_ctrl.sv
module xlseq_ctrl import xlseq_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    uHit,
  input  logic    mHit,
  input  logic    walkAck,
  input  logic    walkFault,
  input  logic    xlCacheable,
  input  logic    xlWriteBack,
  input  logic    accWrite,
  input  logic    l1Ack,
  input  logic    l1Hit,
  input  logic    l2Ack,
  input  logic    l2Hit,
  input  logic    busAck,
  output strobe_t stb,
  output logic    reqReady,
  output logic    walkReq,
  output logic    l1Req,
  output logic    l2Req,
  output logic    busReq,
  output logic    cacheDirty,
  output logic    respDone,
  output logic    respAbort
);
  state_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    case (stateQ)
      ST_IDLE: if (reqValid) begin
        stb.capture = 1'b1;
        stateD      = ST_LOOKU;
      end
      ST_LOOKU: if (uHit) begin
        stb.latchXl = 1'b1;
        stb.xlSrc   = SRC_UTLB;
        stateD      = ST_ATTR;
      end else begin
        stateD = ST_LOOKM;
      end
      ST_LOOKM: if (mHit) begin
        stb.latchXl = 1'b1;
        stb.xlSrc   = SRC_MTLB;
        stb.fillU   = 1'b1;
        stateD      = ST_ATTR;
      end else begin
        stateD = ST_WALK;
      end
      ST_WALK: if (walkAck) begin
        if (walkFault) begin
          stateD = ST_ABORT;
        end else begin
          stb.latchXl = 1'b1;
          stb.xlSrc   = SRC_WALK;
          stb.fillU   = 1'b1;
          stb.fillM   = 1'b1;
          stateD      = ST_ATTR;
        end
      end
      ST_ATTR: stateD = xlCacheable ? ST_L1 : ST_BUS;
      ST_L1: if (l1Ack) begin
        if (!l1Hit) begin
          stateD = ST_L2;
        end else if (!accWrite) begin
          stb.latchRd = 1'b1;
          stb.rdSrc   = RD_L1;
          stateD      = ST_DONE;
        end else begin
          stateD = xlWriteBack ? ST_DONE : ST_BUS;
        end
      end
      ST_L2: if (l2Ack) begin
        if (!l2Hit) begin
          stateD = ST_BUS;
        end else if (!accWrite) begin
          stb.latchRd = 1'b1;
          stb.rdSrc   = RD_L2;
          stateD      = ST_DONE;
        end else begin
          stateD = xlWriteBack ? ST_DONE : ST_BUS;
        end
      end
      ST_BUS: if (busAck) begin
        stb.latchRd = !accWrite;
        stb.rdSrc   = RD_BUS;
        stateD      = ST_DONE;
      end
      ST_DONE:  stateD = ST_IDLE;
      ST_ABORT: stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  assign reqReady   = (stateQ == ST_IDLE);
  assign walkReq    = (stateQ == ST_WALK);
  assign l1Req      = (stateQ == ST_L1);
  assign l2Req      = (stateQ == ST_L2);
  assign busReq     = (stateQ == ST_BUS);
  assign respDone   = (stateQ == ST_DONE);
  assign respAbort  = (stateQ == ST_ABORT);
  assign cacheDirty = accWrite && xlWriteBack && (l1Req || l2Req);

  AST_FAULT_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    walkReq && walkAck && walkFault |=> respAbort && !l1Req && !l2Req && !busReq); // R4
  AST_NC_NO_CACHE: assert property (@(posedge clk) disable iff (!rstN)
    (l1Req || l2Req) |-> xlCacheable); // R6
  AST_L2_AFTER_MISS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(l2Req) |-> $past(l1Req && l1Ack && !l1Hit)); // R7
  AST_WB_HIT_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    ((l1Req && l1Ack && l1Hit) || (l2Req && l2Ack && l2Hit)) && accWrite && xlWriteBack
    |=> respDone && !busReq); // R9
  AST_WT_HIT_BUS: assert property (@(posedge clk) disable iff (!rstN)
    ((l1Req && l1Ack && l1Hit) || (l2Req && l2Ack && l2Hit)) && accWrite && !xlWriteBack
    |=> busReq && accWrite); // R10
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (respDone || respAbort) |=> reqReady && !respDone && !respAbort); // R12
endmodule

// File: rtl/xlate_access_seq.sv
module xlate_access_seq import xlseq_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int UTLB_N = 4,
  parameter int MTLB_N = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              respDone,
  output logic              respAbort,
  output logic [DATA_W-1:0] respRdata,
  output logic              walkReq,
  output logic [VPN_W-1:0]  walkVpn,
  input  logic              walkAck,
  input  logic              walkFault,
  input  logic [PPN_W-1:0]  walkPpn,
  input  logic              walkCacheable,
  input  logic              walkWriteBack,
  output logic [PA_W-1:0]   accPaddr,
  output logic              accWrite,
  output logic [DATA_W-1:0] accWdata,
  output logic              cacheDirty,
  output logic              l1Req,
  input  logic              l1Ack,
  input  logic              l1Hit,
  input  logic [DATA_W-1:0] l1Rdata,
  output logic              l2Req,
  input  logic              l2Ack,
  input  logic              l2Hit,
  input  logic [DATA_W-1:0] l2Rdata,
  output logic              busReq,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRdata
);
  strobe_t stb;
  logic    uHit, mHit, xlCacheable, xlWriteBack;

  xlseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .uHit(uHit), .mHit(mHit),
    .walkAck(walkAck), .walkFault(walkFault), .xlCacheable(xlCacheable),
    .xlWriteBack(xlWriteBack), .accWrite(accWrite), .l1Ack(l1Ack), .l1Hit(l1Hit),
    .l2Ack(l2Ack), .l2Hit(l2Hit), .busAck(busAck), .stb(stb), .reqReady(reqReady),
    .walkReq(walkReq), .l1Req(l1Req), .l2Req(l2Req), .busReq(busReq),
    .cacheDirty(cacheDirty), .respDone(respDone), .respAbort(respAbort)
  );

  xlseq_dp #(.DATA_W(DATA_W), .UTLB_N(UTLB_N), .MTLB_N(MTLB_N)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite), .reqVaddr(reqVaddr),
    .reqWdata(reqWdata), .walkPpn(walkPpn), .walkCacheable(walkCacheable),
    .walkWriteBack(walkWriteBack), .l1Rdata(l1Rdata), .l2Rdata(l2Rdata),
    .busRdata(busRdata), .uHit(uHit), .mHit(mHit), .xlCacheable(xlCacheable),
    .xlWriteBack(xlWriteBack), .walkVpn(walkVpn), .accPaddr(accPaddr),
    .accWrite(accWrite), .accWdata(accWdata), .respRdata(respRdata)
  );
endmodule

// File: tb/xlate_access_seq_bench.sv
module xlate_access_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqVaddr = '0, reqWdata = '0;
  logic        reqReady, respDone, respAbort;
  logic [31:0] respRdata;
  logic        walkReq;
  logic [19:0] walkVpn;
  logic        walkAck = 1'b0, walkFault = 1'b0, walkCacheable = 1'b0, walkWriteBack = 1'b0;
  logic [19:0] walkPpn = '0;
  logic [31:0] accPaddr, accWdata;
  logic        accWrite, cacheDirty;
  logic        l1Req, l2Req, busReq;
  logic        l1Ack = 1'b0, l1Hit = 1'b0, l2Ack = 1'b0, l2Hit = 1'b0, busAck = 1'b0;
  logic [31:0] l1Rdata = '0, l2Rdata = '0, busRdata = '0;

  always #5 clk = ~clk;

  xlate_access_seq u_xlate_access_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqVaddr(reqVaddr), .reqWdata(reqWdata), .respDone(respDone), .respAbort(respAbort),
    .respRdata(respRdata), .walkReq(walkReq), .walkVpn(walkVpn), .walkAck(walkAck),
    .walkFault(walkFault), .walkPpn(walkPpn), .walkCacheable(walkCacheable),
    .walkWriteBack(walkWriteBack), .accPaddr(accPaddr), .accWrite(accWrite),
    .accWdata(accWdata), .cacheDirty(cacheDirty), .l1Req(l1Req), .l1Ack(l1Ack),
    .l1Hit(l1Hit), .l1Rdata(l1Rdata), .l2Req(l2Req), .l2Ack(l2Ack), .l2Hit(l2Hit),
    .l2Rdata(l2Rdata), .busReq(busReq), .busAck(busAck), .busRdata(busRdata)
  );

  int checks = 0;
  int errors = 0;

  byte   expCode[$];
  string expTag[$];
  logic [19:0] uVpn[4];
  bit          uVal[4];
  int          uPtr = 0;
  logic [19:0] mVpn[16];
  bit          mVal[16];
  int          mPtr = 0;
  logic [31:0] expPaddr, expRdata;
  bit          expDirty;

  // Bench page table: fault when low byte is EE, cacheable when bit4 is 0, write-back when bit5 is 1
  function automatic void ptLookup(input logic [19:0] vpn, output bit f, output logic [19:0] p,
                                   output bit c, output bit w);
    f = (vpn[7:0] == 8'hEE);
    p = vpn ^ 20'hA5A50;
    c = !vpn[4];
    w = vpn[5];
  endfunction

  // Agents: one-cycle answer; L1 holds lines with paddr bit3 set, L2 those with bit2 set
  always @(negedge clk) begin
    bit f, c, w;
    logic [19:0] p;
    ptLookup(walkVpn, f, p, c, w);
    walkAck = walkReq; walkFault = f; walkPpn = p; walkCacheable = c; walkWriteBack = w;
    l1Ack = l1Req; l1Hit = accPaddr[3]; l1Rdata = accPaddr ^ 32'h1111_1111;
    l2Ack = l2Req; l2Hit = accPaddr[2]; l2Rdata = accPaddr ^ 32'h2222_2222;
    busAck = busReq; busRdata = accPaddr ^ 32'h3333_3333;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic byte obsCode();
    if (walkReq)   return "W";
    if (l1Req)     return "1";
    if (l2Req)     return "2";
    if (busReq)    return "B";
    if (respDone)  return "D";
    if (respAbort) return "X";
    if (reqReady)  return "I";
    return "-";
  endfunction

  function automatic bit uHas(input logic [19:0] v);
    for (int i = 0; i < 4; i++) if (uVal[i] && uVpn[i] == v) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit mHas(input logic [19:0] v);
    for (int i = 0; i < 16; i++) if (mVal[i] && mVpn[i] == v) return 1'b1;
    return 1'b0;
  endfunction

  task automatic push(input byte c, input string t);
    expCode.push_back(c);
    expTag.push_back(t);
  endtask

  task automatic buildModel(input bit wr, input logic [31:0] va);
    logic [19:0] vpn, p;
    bit f, c, w;
    vpn = va[31:12];
    ptLookup(vpn, f, p, c, w);
    push("-", "R1");
    if (!uHas(vpn)) begin
      push("-", "R2");
      if (mHas(vpn)) begin
        uVpn[uPtr] = vpn; uVal[uPtr] = 1'b1; uPtr = (uPtr + 1) % 4;
      end else begin
        push("W", "R3");
        if (f) begin
          push("X", "R4");
          return;
        end
        mVpn[mPtr] = vpn; mVal[mPtr] = 1'b1; mPtr = (mPtr + 1) % 16;
        uVpn[uPtr] = vpn; uVal[uPtr] = 1'b1; uPtr = (uPtr + 1) % 4;
      end
    end
    push("-", "R5");
    expPaddr = {p, va[11:0]};
    expDirty = wr && w;
    if (!c) begin
      push("B", "R6"); push("D", "R6");
      expRdata = expPaddr ^ 32'h3333_3333;
    end else begin
      push("1", "R7");
      if (expPaddr[3]) begin
        expRdata = expPaddr ^ 32'h1111_1111;
        if (!wr) push("D", "R8");
        else if (w) push("D", "R9");
        else begin push("B", "R10"); push("D", "R10"); end
      end else begin
        push("2", "R7");
        if (expPaddr[2]) begin
          expRdata = expPaddr ^ 32'h2222_2222;
          if (!wr) push("D", "R8");
          else if (w) push("D", "R9");
          else begin push("B", "R10"); push("D", "R10"); end
        end else begin
          expRdata = expPaddr ^ 32'h3333_3333;
          push("B", wr ? "R11" : "R7");
          push("D", wr ? "R11" : "R8");
        end
      end
    end
  endtask

  task automatic runAccess(input bit wr, input logic [31:0] va, input logic [31:0] wd);
    byte   o, code;
    string tg;
    @(negedge clk);
    chk(obsCode() == "I", "R12", "idle and ready before request", 64'(obsCode()), 64'("I"));
    reqValid = 1'b1; reqWrite = wr; reqVaddr = va; reqWdata = wd;
    buildModel(wr, va);
    while (expCode.size() > 0) begin
      @(negedge clk);
      reqValid = 1'b0;
      code = expCode.pop_front();
      tg   = expTag.pop_front();
      o    = obsCode();
      chk(o == code, tg, "port activity", 64'(o), 64'(code));
      if (o == code) begin
        case (code)
          "W": chk(walkVpn == va[31:12], "R3", "walk page", 64'(walkVpn), 64'(va[31:12]));
          "1", "2": begin
            chk(accPaddr == expPaddr, "R7", "cache address", 64'(accPaddr), 64'(expPaddr));
            chk(cacheDirty == expDirty, expDirty ? "R9" : "R10", "dirty mark",
                64'(cacheDirty), 64'(expDirty));
          end
          "B": begin
            chk(accPaddr == expPaddr && accWrite == wr, tg, "bus address/direction",
                {31'b0, accWrite, accPaddr}, {31'b0, wr, expPaddr});
            if (wr) chk(accWdata == wd, tg, "bus write data", 64'(accWdata), 64'(wd));
          end
          "D": if (!wr) chk(respRdata == expRdata, "R8", "read data", 64'(respRdata), 64'(expRdata));
          default: ;
        endcase
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R12 watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) uVal[i] = 1'b0;
    for (int i = 0; i < 16; i++) mVal[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(reqReady && !walkReq && !l1Req && !l2Req && !busReq && !respDone && !respAbort,
        "R12", "reset state", {57'b0, reqReady, walkReq, l1Req, l2Req, busReq, respDone, respAbort},
        64'h40);
    runAccess(1'b0, 32'h0000_1008, '0);          // R3 walk, L1 read hit
    runAccess(1'b0, 32'h0000_100C, '0);          // R1 micro hit
    runAccess(1'b1, 32'h0002_1008, 32'hCAFE_0001); // R9 write-back hit
    runAccess(1'b1, 32'h0000_1008, 32'hCAFE_0002); // R10 write-through hit
    runAccess(1'b0, 32'h0000_1004, '0);          // R8 L2 hit
    runAccess(1'b0, 32'h0000_1000, '0);          // R7 bus after both misses
    runAccess(1'b1, 32'h0000_1000, 32'hCAFE_0003); // R11 write miss
    runAccess(1'b1, 32'h0002_1004, 32'hCAFE_0004); // R9 L2 write-back hit
    runAccess(1'b0, 32'h0001_100C, '0);          // R6 non-cacheable read
    runAccess(1'b1, 32'h0001_100C, 32'hCAFE_0005); // R6 non-cacheable write
    runAccess(1'b0, 32'h000E_E000, '0);          // R4 fault
    runAccess(1'b0, 32'h000E_E000, '0);          // R4 walked again
    for (int i = 1; i <= 4; i++) runAccess(1'b0, {20'h00100 + 20'(i), 12'h008}, '0);
    runAccess(1'b0, 32'h0000_100C, '0);          // R2 main hit
    runAccess(1'b0, 32'h0000_100C, '0);          // R2 promoted to micro
    for (int i = 0; i < 20; i++) runAccess(1'b0, {20'h00200 + 20'(i), 12'h008}, '0);
    runAccess(1'b0, 32'h0000_1008, '0);          // R5 evicted, walk again
    for (int i = 0; i < 60; i++)
      runAccess(i % 3 == 0, {20'h00300 + 20'((i * 7) % 24), 12'(i * 4)}, 32'(i * 32'h0101_0101));
    @(negedge clk);
    chk(obsCode() == "I", "R12", "idle at end", 64'(obsCode()), 64'("I"));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule